// File: doc/BRIEF.md
# AXI4-Lite Slave Bridge with Byte-Run Write Splitting

This block is an AXI4-Lite slave that forwards single-beat accesses to a plain back-end port. Every address it receives is first rounded down to a whole bus word. A read becomes one full-word back-end read. A write becomes one back-end write for each group of adjacent enabled bytes in the write strobe. Each back-end write carries the byte address of the group's first byte, a byte count, and the data shifted so that this first byte sits in bits 7:0. The back-end can flag an error on any access, and the bridge reports it on the AXI response.

Reads and writes run in two separate engines, so a stalled back-end write does not hold up reads. Each of the five AXI channels passes through its own two-entry buffer. The protection fields are accepted and have no effect. The back-end samples its error flag and read data in the same cycle as its valid/ready handshake.

Top module: `axil_byterun_bridge`

## Requirements
- R1: The back-end address of every access is built from the AXI address with its low log2(bytes per word) bits cleared. A write run adds its starting lane to that aligned address.
- R2: The bridge returns exactly one B response for each AW transfer paired with one W transfer. A lone AW with no W produces neither a B response nor a back-end write.
- R3: Each maximal run of consecutive set strobe bits produces one back-end write. Its address is aligned_address + first_lane and its count is the run length. Its data is the write word shifted right by 8*first_lane, so lane i of the bus is byte address aligned_address + i. Runs are issued in ascending lane order.
- R4: A write whose strobe is all zeros makes no back-end write but still returns B with OKAY (2'b00).
- R5: BRESP is SLVERR (2'b10) if any back-end write of the transfer reported an error. Otherwise it is OKAY (2'b00).
- R6: Each AR transfer makes exactly one back-end read at the aligned address. RDATA is the back-end data with RRESP OKAY (2'b00). On a back-end error, RRESP is SLVERR (2'b10) and RDATA is all zeros.
- R7: When the B consumer stalls, no more than 5 write transactions are accepted: 2 in the B buffer, 1 held in the engine and 2 each in the AW and W buffers. The same bound of 5 applies to reads when R stalls.
- R8: Once asserted, every valid output (AXI B/R and both back-end requests) stays asserted with a stable payload until it is accepted.
- R9: While back-end writes are stalled, a read still completes, and the pending write produces no B response until its back-end write is accepted.
- R10: While rst is high, every ready and valid output is low. After reset, responses that were buffered before it are gone.
- R11: The values of s_awprot and s_arprot have no effect on any output.
- R12: With the back-end always ready, B is visible 2+k cycles after the W handshake cycle for a write of k runs. For k = 0 it is visible after 2 cycles. R is visible 2 cycles after the AR handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awprot | input | 3 | Write protection (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arprot | input | 3 | Read protection (ignored) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| bew_valid | output | 1 | Back-end write request valid |
| bew_ready | input | 1 | Back-end write accepted |
| bew_addr | output | ADDR_W | Byte address of the run's first byte |
| bew_count | output | $clog2(DATA_W/8+1) | Bytes in the run |
| bew_data | output | DATA_W | Run data, first byte in bits 7:0 |
| bew_err | input | 1 | Back-end write error, sampled at handshake |
| ber_valid | output | 1 | Back-end read request valid |
| ber_ready | input | 1 | Back-end read accepted |
| ber_addr | output | ADDR_W | Word-aligned read address |
| ber_rdata | input | DATA_W | Read data, sampled at handshake |
| ber_err | input | 1 | Back-end read error, sampled at handshake |

## Verification
Several registers lie on each path. The W handshake edge fills the W buffer, the next edge moves the pair into the write engine, and each run then takes one edge. The edge after the last run puts the response into the B buffer, so a write of k runs shows B at the (2+k)-th falling edge after the W handshake, and a zero-strobe write at the second. A read shows R at the second falling edge after its AR handshake. The bench drives inputs and samples outputs only on falling edges. It measures these delays in directed cases with the back-end held ready. In random runs, where the back-end stalls at random, it waits for the valid signals instead.

// File: rtl/axbr_pkg.sv
package axbr_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } axbr_resp_e;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_RUN  = 2'd1,
        WR_RESP = 2'd2
    } axbr_wr_state_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_REQ  = 1'b1
    } axbr_rd_state_e;

    function automatic axbr_resp_e resp_from_err(input logic err);
        return err ? RESP_SLVERR : RESP_OKAY;
    endfunction

endpackage

// File: rtl/axbr_fifo2.sv
module axbr_fifo2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam logic [1:0] DEPTH = 2'd2;

    logic [W-1:0] mem_q [2];
    logic         wr_ptr_q, rd_ptr_q;
    logic [1:0]   cnt_q;
    logic         push, pop;

    assign in_ready  = !rst && (cnt_q != DEPTH);
    assign out_valid = !rst && (cnt_q != 2'd0);
    assign out_data  = mem_q[rd_ptr_q];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_ptr_q] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= 1'b0;
            rd_ptr_q <= 1'b0;
            cnt_q    <= 2'd0;
        end else begin
            if (push) wr_ptr_q <= ~wr_ptr_q;
            if (pop)  rd_ptr_q <= ~rd_ptr_q;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 2'd1;
                2'b01:   cnt_q <= cnt_q - 2'd1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R8: a presented entry stays put until taken
    assert_buf_hold_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: rtl/axbr_wr_engine.sv
module axbr_wr_engine
    import axbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int LB    = $clog2(LANES),
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int WA    = ADDR_W - LB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [WA-1:0]     aw_word,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic [LANES-1:0]  w_strb,
    output logic              b_valid,
    input  logic              b_ready,
    output axbr_resp_e        b_resp,
    output logic              bew_valid,
    input  logic              bew_ready,
    output logic [ADDR_W-1:0] bew_addr,
    output logic [CNT_W-1:0]  bew_count,
    output logic [DATA_W-1:0] bew_data,
    input  logic              bew_err
);
    axbr_wr_state_e      state_q;
    logic [WA-1:0]       word_q;
    logic [DATA_W-1:0]   data_q;
    logic [LANES-1:0]    mask_q;
    logic                err_q;

    logic [LB-1:0]       run_first;
    logic [CNT_W-1:0]    run_len;
    logic [LANES-1:0]    run_mask, mask_next;
    logic                found_c, broken_c;

    // lowest set lane, then the run of set lanes that starts there
    always_comb begin
        found_c   = 1'b0;
        run_first = '0;
        for (int i = 0; i < LANES; i++) begin
            if (!found_c && mask_q[i]) begin
                run_first = LB'(i);
                found_c   = 1'b1;
            end
        end
        broken_c = 1'b0;
        run_len  = '0;
        run_mask = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i >= int'(run_first)) begin
                if (mask_q[i] && !broken_c) begin
                    run_len     = run_len + CNT_W'(1);
                    run_mask[i] = 1'b1;
                end else begin
                    broken_c = 1'b1;
                end
            end
        end
        mask_next = mask_q & ~run_mask;
    end

    assign aw_ready  = !rst && (state_q == WR_IDLE) && w_valid;
    assign w_ready   = !rst && (state_q == WR_IDLE) && aw_valid;
    assign bew_valid = !rst && (state_q == WR_RUN);
    assign bew_addr  = {word_q, run_first};
    assign bew_count = run_len;
    assign bew_data  = data_q >> {run_first, 3'b000};
    assign b_valid   = !rst && (state_q == WR_RESP);
    assign b_resp    = resp_from_err(err_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WR_IDLE;
            word_q  <= '0;
            data_q  <= '0;
            mask_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                WR_IDLE: if (aw_valid && w_valid) begin
                    word_q  <= aw_word;
                    data_q  <= w_data;
                    mask_q  <= w_strb;
                    err_q   <= 1'b0;
                    state_q <= (w_strb == '0) ? WR_RESP : WR_RUN;
                end
                WR_RUN: if (bew_valid && bew_ready) begin
                    mask_q <= mask_next;
                    err_q  <= err_q | bew_err;
                    if (mask_next == '0) state_q <= WR_RESP;
                end
                WR_RESP: if (b_ready) state_q <= WR_IDLE;
                default: state_q <= WR_IDLE;
            endcase
        end
    end

    // R3: a run is non-empty and stays inside the word
    assert_run_fits_R3: assert property (@(posedge clk) disable iff (rst)
        bew_valid |-> (bew_count != '0) &&
                      (int'(bew_addr[LB-1:0]) + int'(bew_count) <= LANES));

    // R3: the next run of the same transfer starts beyond a gap
    assert_runs_ascend_R3: assert property (@(posedge clk) disable iff (rst)
        bew_valid && bew_ready |=> !bew_valid ||
            (bew_addr > $past(bew_addr) + ADDR_W'($past(bew_count))));

    // R8: back-end write request held until accepted
    assert_bew_hold_R8: assert property (@(posedge clk) disable iff (rst)
        bew_valid && !bew_ready |=> bew_valid && $stable(bew_addr) &&
                                    $stable(bew_count) && $stable(bew_data));

endmodule

// File: rtl/axbr_rd_engine.sv
module axbr_rd_engine
    import axbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int LB    = $clog2(LANES),
    localparam int WA    = ADDR_W - LB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [WA-1:0]     ar_word,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [DATA_W-1:0] r_data,
    output axbr_resp_e        r_resp,
    output logic              ber_valid,
    input  logic              ber_ready,
    output logic [ADDR_W-1:0] ber_addr,
    input  logic [DATA_W-1:0] ber_rdata,
    input  logic              ber_err
);
    axbr_rd_state_e state_q;
    logic [WA-1:0]  word_q;

    assign ar_ready  = !rst && (state_q == RD_IDLE);
    assign ber_valid = !rst && (state_q == RD_REQ) && r_ready;
    assign ber_addr  = {word_q, LB'(0)};
    assign r_valid   = ber_valid && ber_ready;
    assign r_data    = ber_err ? '0 : ber_rdata;
    assign r_resp    = resp_from_err(ber_err);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
            word_q  <= '0;
        end else begin
            case (state_q)
                RD_IDLE: if (ar_valid) begin
                    word_q  <= ar_word;
                    state_q <= RD_REQ;
                end
                RD_REQ: if (ber_valid && ber_ready) state_q <= RD_IDLE;
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    // R6: one back-end read per request, never two back to back
    assert_one_read_R6: assert property (@(posedge clk) disable iff (rst)
        ber_valid && ber_ready |=> !ber_valid);

    // R8: back-end read request held until accepted
    assert_ber_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ber_valid && !ber_ready |=> ber_valid && $stable(ber_addr));

endmodule

// File: rtl/axil_byterun_bridge.sv
module axil_byterun_bridge
    import axbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int LB    = $clog2(LANES),
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int WA    = ADDR_W - LB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic [2:0]        s_awprot,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [LANES-1:0]  s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic [2:0]        s_arprot,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              bew_valid,
    input  logic              bew_ready,
    output logic [ADDR_W-1:0] bew_addr,
    output logic [CNT_W-1:0]  bew_count,
    output logic [DATA_W-1:0] bew_data,
    input  logic              bew_err,
    output logic              ber_valid,
    input  logic              ber_ready,
    output logic [ADDR_W-1:0] ber_addr,
    input  logic [DATA_W-1:0] ber_rdata,
    input  logic              ber_err
);
    logic                     unused_inputs;
    assign unused_inputs = ^{s_awprot, s_arprot, s_awaddr[LB-1:0], s_araddr[LB-1:0]};

    logic              aw_q_valid, aw_q_ready, w_q_valid, w_q_ready;
    logic [WA-1:0]     aw_q_word, ar_q_word;
    logic [DATA_W-1:0] w_q_data;
    logic [LANES-1:0]  w_q_strb;
    logic              eng_b_valid, eng_b_ready;
    axbr_resp_e        eng_b_resp;
    logic              ar_q_valid, ar_q_ready;
    logic              eng_r_valid, eng_r_ready;
    logic [DATA_W-1:0] eng_r_data;
    axbr_resp_e        eng_r_resp;

    axbr_fifo2 #(.W(WA)) u_aw_buf (
        .clk(clk), .rst(rst),
        .in_valid(s_awvalid), .in_ready(s_awready), .in_data(s_awaddr[ADDR_W-1:LB]),
        .out_valid(aw_q_valid), .out_ready(aw_q_ready), .out_data(aw_q_word));

    axbr_fifo2 #(.W(DATA_W + LANES)) u_w_buf (
        .clk(clk), .rst(rst),
        .in_valid(s_wvalid), .in_ready(s_wready), .in_data({s_wstrb, s_wdata}),
        .out_valid(w_q_valid), .out_ready(w_q_ready), .out_data({w_q_strb, w_q_data}));

    axbr_fifo2 #(.W(2)) u_b_buf (
        .clk(clk), .rst(rst),
        .in_valid(eng_b_valid), .in_ready(eng_b_ready), .in_data(eng_b_resp),
        .out_valid(s_bvalid), .out_ready(s_bready), .out_data(s_bresp));

    axbr_fifo2 #(.W(WA)) u_ar_buf (
        .clk(clk), .rst(rst),
        .in_valid(s_arvalid), .in_ready(s_arready), .in_data(s_araddr[ADDR_W-1:LB]),
        .out_valid(ar_q_valid), .out_ready(ar_q_ready), .out_data(ar_q_word));

    axbr_fifo2 #(.W(DATA_W + 2)) u_r_buf (
        .clk(clk), .rst(rst),
        .in_valid(eng_r_valid), .in_ready(eng_r_ready), .in_data({eng_r_resp, eng_r_data}),
        .out_valid(s_rvalid), .out_ready(s_rready), .out_data({s_rresp, s_rdata}));

    axbr_wr_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst(rst),
        .aw_valid(aw_q_valid), .aw_ready(aw_q_ready), .aw_word(aw_q_word),
        .w_valid(w_q_valid), .w_ready(w_q_ready), .w_data(w_q_data), .w_strb(w_q_strb),
        .b_valid(eng_b_valid), .b_ready(eng_b_ready), .b_resp(eng_b_resp),
        .bew_valid(bew_valid), .bew_ready(bew_ready), .bew_addr(bew_addr),
        .bew_count(bew_count), .bew_data(bew_data), .bew_err(bew_err));

    axbr_rd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst(rst),
        .ar_valid(ar_q_valid), .ar_ready(ar_q_ready), .ar_word(ar_q_word),
        .r_valid(eng_r_valid), .r_ready(eng_r_ready), .r_data(eng_r_data), .r_resp(eng_r_resp),
        .ber_valid(ber_valid), .ber_ready(ber_ready), .ber_addr(ber_addr),
        .ber_rdata(ber_rdata), .ber_err(ber_err));

    // R10: handshake outputs stay low throughout reset
    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |-> !(s_awready || s_wready || s_bvalid || s_arready ||
                  s_rvalid || bew_valid || ber_valid));

    // R6: an erroring read returns zero data
    assert_err_zero_R6: assert property (@(posedge clk) disable iff (rst)
        s_rvalid && (s_rresp == 2'b10) |-> (s_rdata == '0));

    // R5: only OKAY or SLVERR ever appear on B
    assert_bresp_legal_R5: assert property (@(posedge clk) disable iff (rst)
        s_bvalid |-> (s_bresp == 2'b00) || (s_bresp == 2'b10));

endmodule

// File: tb/test_axil_byterun_bridge.sv
module test_axil_byterun_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_awvalid = 0, s_awready;
    logic [31:0] s_awaddr = '0;
    logic [2:0]  s_awprot = '0;
    logic        s_wvalid = 0, s_wready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_bvalid, s_bready = 0;
    logic [1:0]  s_bresp;
    logic        s_arvalid = 0, s_arready;
    logic [31:0] s_araddr = '0;
    logic [2:0]  s_arprot = '0;
    logic        s_rvalid, s_rready = 0;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        bew_valid, bew_ready = 0;
    logic [31:0] bew_addr, bew_data;
    logic [2:0]  bew_count;
    logic        bew_err;
    logic        ber_valid, ber_ready = 0;
    logic [31:0] ber_addr, ber_rdata;
    logic        ber_err;

    int checks = 0;
    int fails  = 0;
    int ready_mode = 1;  // 0 random, 1 always ready, 2 writes stalled

    always #10 clk = ~clk;

    axil_byterun_bridge i_axil_byterun_bridge (
        .clk(clk), .rst(rst),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awprot(s_awprot),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arprot(s_arprot),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .bew_valid(bew_valid), .bew_ready(bew_ready), .bew_addr(bew_addr),
        .bew_count(bew_count), .bew_data(bew_data), .bew_err(bew_err),
        .ber_valid(ber_valid), .ber_ready(ber_ready), .ber_addr(ber_addr),
        .ber_rdata(ber_rdata), .ber_err(ber_err));

    // back-end model: errors on address bit 6
    function automatic logic [31:0] model_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0F0F;
    endfunction

    assign bew_err   = bew_addr[6];
    assign ber_err   = ber_addr[6];
    assign ber_rdata = model_word(ber_addr);

    always @(negedge clk) begin
        case (ready_mode)
            0:       begin bew_ready = ($urandom_range(3) != 0); ber_ready = ($urandom_range(3) != 0); end
            2:       begin bew_ready = 1'b0; ber_ready = 1'b1; end
            default: begin bew_ready = 1'b1; ber_ready = 1'b1; end
        endcase
    end

    logic [31:0] wl_addr[$];
    int          wl_cnt[$];
    logic [31:0] wl_data[$];
    logic [31:0] rl_addr[$];

    always @(posedge clk) begin
        if (!rst) begin
            if (bew_valid && bew_ready) begin
                wl_addr.push_back(bew_addr);
                wl_cnt.push_back(int'(bew_count));
                wl_data.push_back(bew_data);
            end
            if (ber_valid && ber_ready) rl_addr.push_back(ber_addr);
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic aw_send(input logic [31:0] a, input logic [2:0] p);
        s_awaddr = a; s_awprot = p; s_awvalid = 1'b1;
        while (!s_awready) @(negedge clk);
        @(negedge clk);
        s_awvalid = 1'b0;
    endtask

    task automatic w_send(input logic [31:0] d, input logic [3:0] s);
        s_wdata = d; s_wstrb = s; s_wvalid = 1'b1;
        while (!s_wready) @(negedge clk);
        @(negedge clk);
        s_wvalid = 1'b0;
    endtask

    task automatic ar_send(input logic [31:0] a, input logic [2:0] p);
        s_araddr = a; s_arprot = p; s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
    endtask

    task automatic b_recv(output logic [1:0] r, output int lat);
        s_bready = 1'b1; lat = 0;
        while (!s_bvalid) begin @(negedge clk); lat++; end
        r = s_bresp;
        @(negedge clk);
        s_bready = 1'b0;
    endtask

    task automatic r_recv(output logic [31:0] d, output logic [1:0] r, output int lat);
        s_rready = 1'b1; lat = 0;
        while (!s_rvalid) begin @(negedge clk); lat++; end
        d = s_rdata; r = s_rresp;
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    task automatic do_write(input string tag, input logic [31:0] a, input logic [31:0] d,
                            input logic [3:0] s, input logic [2:0] p, input int exp_lat);
        logic [1:0]  resp;
        logic [31:0] base, msk;
        int lat, j, i, st, len;
        bit experr;
        wl_addr.delete(); wl_cnt.delete(); wl_data.delete();
        aw_send(a, p);
        w_send(d, s);
        b_recv(resp, lat);
        base = {a[31:2], 2'b00};
        j = 0; i = 0; experr = 0;
        while (i < 4) begin
            if (s[i]) begin
                st = i;
                while (i < 4 && s[i]) i++;
                len = i - st;
                msk = (len == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * len)) - 32'd1);
                experr |= base[6];
                if (j < wl_addr.size()) begin
                    check({tag, " R1/R3 run addr"}, wl_addr[j], base + 32'(st));
                    check({tag, " R3 run count"}, 32'(wl_cnt[j]), 32'(len));
                    check({tag, " R3 run data"}, wl_data[j] & msk, (d >> (8 * st)) & msk);
                end
                j++;
            end else begin
                i++;
            end
        end
        check({tag, " R3/R4 back-end write count"}, 32'(wl_addr.size()), 32'(j));
        check({tag, " R5 bresp"}, 32'(resp), experr ? 32'd2 : 32'd0);
        if (exp_lat >= 0) check({tag, " R12 write latency"}, 32'(lat), 32'(exp_lat));
    endtask

    task automatic do_read(input string tag, input logic [31:0] a, input logic [2:0] p,
                           input int exp_lat);
        logic [31:0] d, al;
        logic [1:0]  resp;
        int lat;
        rl_addr.delete();
        ar_send(a, p);
        r_recv(d, resp, lat);
        al = {a[31:2], 2'b00};
        check({tag, " R6 back-end read count"}, 32'(rl_addr.size()), 32'd1);
        if (rl_addr.size() > 0) check({tag, " R1 read addr"}, rl_addr[0], al);
        check({tag, " R6 rdata"}, d, al[6] ? 32'd0 : model_word(al));
        check({tag, " R6 rresp"}, 32'(resp), al[6] ? 32'd2 : 32'd0);
        if (exp_lat >= 0) check({tag, " R12 read latency"}, 32'(lat), 32'(exp_lat));
    endtask

    function automatic logic [31:0] quiet_vec();
        return {25'd0, s_awready, s_wready, s_bvalid, s_arready, s_rvalid, bew_valid, ber_valid};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [1:0]  resp;
        logic [31:0] d;
        int lat, naw, nw, nar;
        int unsigned seed_set;
        seed_set = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        check("R10 quiet during reset", quiet_vec(), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 no B after reset", 32'(s_bvalid), 32'd0);

        // directed cases, back-end always ready
        ready_mode = 1;
        do_write("full word unaligned", 32'h0000_0103, 32'hA1B2_C3D4, 4'b1111, 3'd0, 3);
        do_write("zero strobe R4", 32'h0000_0010, 32'h1122_3344, 4'b0000, 3'd0, 2);
        do_write("two single lanes", 32'h0000_0022, 32'h5566_7788, 4'b0101, 3'd0, 4);
        do_write("lane0 plus upper pair", 32'h0000_0031, 32'hCAFE_F00D, 4'b1101, 3'd0, 4);
        do_write("middle pair error", 32'h0000_0041, 32'h0BAD_BEEF, 4'b0110, 3'd0, 3);
        do_write("zero strobe at error addr R4", 32'h0000_0044, 32'h0, 4'b0000, 3'd0, 2);
        do_read("unaligned read", 32'h0000_0107, 3'd0, 2);
        do_read("error read", 32'h0000_004C, 3'd0, 2);
        do_read("prot zero R11", 32'h0000_0088, 3'd0, 2);
        do_read("prot all ones R11", 32'h0000_0088, 3'd7, 2);
        do_write("prot all ones R11", 32'h0000_0090, 32'h1357_9BDF, 4'b1011, 3'd7, 4);

        // R2: lone AW makes nothing happen
        wl_addr.delete();
        aw_send(32'h0000_0300, 3'd0);
        repeat (6) @(negedge clk);
        check("R2 lone AW no B", 32'(s_bvalid), 32'd0);
        check("R2 lone AW no back-end write", 32'(wl_addr.size()), 32'd0);
        w_send(32'h0000_00EE, 4'b0001);
        b_recv(resp, lat);
        check("R2 paired B resp", 32'(resp), 32'd0);
        check("R2 one back-end write", 32'(wl_addr.size()), 32'd1);

        // R9: reads proceed while back-end writes are stalled
        ready_mode = 2;
        wl_addr.delete(); wl_cnt.delete(); wl_data.delete();
        aw_send(32'h0000_0200, 3'd0);
        w_send(32'h0000_1234, 4'b0011);
        do_read("read during write stall R9", 32'h0000_0180, 3'd0, -1);
        check("R9 no B while stalled", 32'(s_bvalid), 32'd0);
        check("R9 no write while stalled", 32'(wl_addr.size()), 32'd0);
        ready_mode = 1;
        b_recv(resp, lat);
        check("R9 B after release", 32'(resp), 32'd0);
        check("R9 write after release", 32'(wl_addr.size()), 32'd1);

        // R7: write-side capacity with B stalled
        wl_addr.delete(); wl_cnt.delete(); wl_data.delete();
        s_bready = 1'b0;
        s_awaddr = 32'h0000_0200; s_wdata = 32'h0000_00AB; s_wstrb = 4'b0001;
        s_awvalid = 1'b1; s_wvalid = 1'b1;
        naw = 0; nw = 0;
        repeat (30) begin
            if (s_awready) naw++;
            if (s_wready) nw++;
            @(negedge clk);
        end
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        check("R7 AW accepted while B stalled", 32'(naw), 32'd5);
        check("R7 W accepted while B stalled", 32'(nw), 32'd5);
        for (int k = 0; k < 5; k++) begin
            b_recv(resp, lat);
            check("R7 drained B resp", 32'(resp), 32'd0);
        end
        repeat (3) @(negedge clk);
        check("R7 no extra B", 32'(s_bvalid), 32'd0);
        check("R7 back-end writes", 32'(wl_addr.size()), 32'd5);

        // R7: read-side capacity with R stalled
        s_rready = 1'b0;
        s_araddr = 32'h0000_0204; s_arvalid = 1'b1;
        nar = 0;
        repeat (30) begin
            if (s_arready) nar++;
            @(negedge clk);
        end
        s_arvalid = 1'b0;
        check("R7 AR accepted while R stalled", 32'(nar), 32'd5);
        for (int k = 0; k < 5; k++) begin
            r_recv(d, resp, lat);
            check("R7 drained rdata", d, model_word(32'h0000_0204));
        end
        repeat (3) @(negedge clk);
        check("R7 no extra R", 32'(s_rvalid), 32'd0);

        // R8: held valid stays with payload under B stall
        s_bready = 1'b0;
        aw_send(32'h0000_0040, 3'd0);
        w_send(32'h0, 4'b0001);
        repeat (4) @(negedge clk);
        resp = s_bresp;
        repeat (3) @(negedge clk);
        check("R8 bvalid held", 32'(s_bvalid), 32'd1);
        check("R8 bresp stable", 32'(s_bresp), 32'(resp));
        b_recv(resp, lat);
        check("R8/R5 held resp", 32'(resp), 32'd2);

        // randomized traffic with a stalling back-end
        ready_mode = 0;
        for (int n = 0; n < 60; n++) begin
            do_write("random write", {22'd0, 10'($urandom)}, $urandom, 4'($urandom),
                     3'($urandom), -1);
        end
        for (int n = 0; n < 40; n++) begin
            do_read("random read", {22'd0, 10'($urandom)}, 3'($urandom), -1);
        end
        ready_mode = 1;

        // R10: reset flushes buffered responses
        s_bready = 1'b0; s_rready = 1'b0;
        aw_send(32'h0000_0100, 3'd0);
        w_send(32'h0000_0001, 4'b0001);
        ar_send(32'h0000_0100, 3'd0);
        repeat (5) @(negedge clk);
        check("R10 B pending before reset", 32'(s_bvalid), 32'd1);
        check("R10 R pending before reset", 32'(s_rvalid), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        check("R10 quiet in reset", quiet_vec(), 32'd0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 B flushed", 32'(s_bvalid), 32'd0);
        check("R10 R flushed", 32'(s_rvalid), 32'd0);
        do_write("after reset", 32'h0000_0104, 32'h89AB_CDEF, 4'b1100, 3'd0, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule